// File: doc/BRIEF.md
# Block-Partitioned Memory with Per-Block Power Modes

A word-addressed storage array divided into a power-of-two number of independent blocks. Each incoming address splits into a block field, a row field and a column field. Only the block being accessed has its decoders and read path switched on; every other block sits idle with its enable low. Inside a block, a row holds one line of several data words, and the column field picks one word out of that line.

Every access runs as a short cycle-level sequence rather than a single-cycle lookup. A read steps through bit-line precharge, a one-cycle word-line pulse and a sense phase that presents the data. A write first drives the bit values and then pulses the word line. These phase strobes are brought out as outputs so that a physical array can be driven from them.

Each block has its own two-bit power mode input. Sleep keeps the block's contents but makes it unreachable. Power-down discards the contents: every word is marked invalid, and reading it returns an error flag until it is written again. An access aimed at a block that is not usable holds the handshake off. It proceeds only once the block is back in active mode and a fixed wake-up interval has passed.

Top module: `pm_banked_mem`

## Requirements
- R1: The address is {block, row, column}, with the block field in the most significant bits and the column field in the least significant bits. With defaults that is addr[6:5] block, addr[4:2] row and addr[1:0] column, so each block has 32 words. A write followed by a read of the same address returns the written word, and words that differ in any one field are stored separately.
- R2: bank_en_o has at most one bit set. That bit is the bit of the latched block, and it is set only during the precharge, word-line, sense, drive and write-pulse phases. It is zero while the block is idle or waiting, and an unusable block does not stall accesses to other blocks.
- R3: A read accepted at a clock edge spends one cycle with pre_o high, then one cycle with wl_o high, then one cycle with se_o and ready_o high. ready_o is therefore seen in the third cycle after the accepting edge.
- R4: se_o is never high while pre_o or wl_o is high, and wl_o never stays high for two consecutive cycles.
- R5: A write spends one cycle with bdrv_o high and wl_o low, then one cycle with bdrv_o, wl_o and ready_o high. The word is stored at the edge that ends the second cycle.
- R6: The mode field of block b is mode_i[2b+1:2b]. 00 means active, 01 means sleep, and 10 or 11 means power-down.
- R7: A block put to sleep and then woken returns the words it held, with rerr_o low.
- R8: After reset, and after any cycle in which a block was powered down, a read of a word not written since returns rerr_o=1 and rdata_o=0. Outside the sense cycle, rdata_o and rerr_o are 0.
- R9: An access to a block is started only at an edge where that block's mode is 00 and was also 00 at the preceding WAKE_CYC edges. Until then, ready_o and bank_en_o stay low.
- R10: A request is taken when req_i is high at an edge while the block is idle. The requester holds req_i, we_i, addr_i and wdata_i until it sees ready_o, and ready_o is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | BANK_W+ROW_W+COL_W | Word address {block, row, column} |
| wdata_i | input | DATA_W | Write data |
| mode_i | input | 2*NBANK | Per-block power mode, two bits per block |
| ready_o | output | 1 | Access completes at the end of this cycle |
| rdata_o | output | DATA_W | Read data, valid with ready_o on reads |
| rerr_o | output | 1 | Read of an invalid word |
| bank_en_o | output | NBANK | Decoder and read-path enable per block |
| pre_o | output | 1 | Bit-line precharge phase |
| wl_o | output | 1 | Word-line pulse |
| se_o | output | 1 | Sense-enable phase |
| bdrv_o | output | 1 | Write bit-line drive phase |

## Verification
Writes and reads are issued to addresses that differ only in column, only in row, and only in block. Crosstalk between fields or a wrong field position then shows up as a wrong read value. A block is put to sleep with a request already waiting for it, while another block stays in use. This separates correct stalling and wake-up counting from a global stall or an early start, and the read after wake-up shows whether the contents were retained. Two blocks are powered down through the two power-down encodings, then re-written in part, so that invalid words raise the error flag while fresh words do not. A per-cycle reference model compares every phase strobe, enable and data output throughout.

// File: rtl/pmb_pkg.sv
`timescale 1ns/1ps
package pmb_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_WAIT,
      PH_PRE,
      PH_WL,
      PH_SNS,
      PH_WDRV,
      PH_WWL
   } ph_e;

   function automatic logic mode_active(input logic [1:0] m);
      return m == 2'b00;
   endfunction

   function automatic logic mode_off(input logic [1:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/pmb_wake.sv
`timescale 1ns/1ps
module pmb_wake #(
   parameter int WAKE_CYC = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   output logic       ok_o
);
   import pmb_pkg::*;

   logic act;
   assign act = mode_active(mode_i);

   generate
      if (WAKE_CYC == 0) begin : g_nowait
         assign ok_o = act;
      end else begin : g_count
         localparam int CW = $clog2(WAKE_CYC + 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (!act)       cnt <= CW'(WAKE_CYC);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end

         assign ok_o = act && (cnt == '0);

         p_leave_active_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !act |=> !ok_o)
            else $error("block usable right after a non-active mode");
      end
   endgenerate

endmodule

// File: rtl/pmb_bank.sv
`timescale 1ns/1ps
module pmb_bank #(
   parameter int ROW_W  = 3,
   parameter int COL_W  = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              pd_i,
   input  logic              wr_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvld_o
);
   localparam int ROWS   = 1 << ROW_W;
   localparam int COLS   = 1 << COL_W;
   localparam int WORDS  = ROWS * COLS;
   localparam int LINE_W = COLS * DATA_W;

   logic [LINE_W-1:0] arr [ROWS];
   logic [WORDS-1:0]  vld;
   logic [LINE_W-1:0] line;
   logic              wr_en;

   assign wr_en = wr_i && en_i;

   always_ff @(posedge clk) begin
      if (wr_en) arr[row_i][col_i*DATA_W +: DATA_W] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld <= '0;
      else if (pd_i)   vld <= '0;
      else if (wr_en)  vld[{row_i, col_i}] <= 1'b1;
   end

   assign line    = arr[row_i];
   assign rdata_o = en_i ? line[col_i*DATA_W +: DATA_W] : '0;
   assign rvld_o  = en_i && vld[{row_i, col_i}];

   p_off_drops_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pd_i |=> (vld == '0))
      else $error("valid bits survive power-down");

endmodule

// File: rtl/pmb_seq.sv
`timescale 1ns/1ps
module pmb_seq #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              ok_i,
   output logic [BANK_W-1:0] tgt_bank_o,
   output logic [ADDR_W-1:0] lat_addr_o,
   output logic [DATA_W-1:0] lat_wdata_o,
   output logic              act_o,
   output logic              wr_o,
   output logic              pre_o,
   output logic              wl_o,
   output logic              se_o,
   output logic              bdrv_o,
   output logic              ready_o
);
   import pmb_pkg::*;

   ph_e st, nxt;
   logic lat_we;

   always_comb begin
      nxt = st;
      case (st)
         PH_IDLE: if (req_i) nxt = !ok_i ? PH_WAIT : (we_i ? PH_WDRV : PH_PRE);
         PH_WAIT: if (ok_i)  nxt = lat_we ? PH_WDRV : PH_PRE;
         PH_PRE:  nxt = PH_WL;
         PH_WL:   nxt = PH_SNS;
         PH_SNS:  nxt = PH_IDLE;
         PH_WDRV: nxt = PH_WWL;
         PH_WWL:  nxt = PH_IDLE;
         default: nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= PH_IDLE;
         lat_we      <= 1'b0;
         lat_addr_o  <= '0;
         lat_wdata_o <= '0;
      end else begin
         st <= nxt;
         if (st == PH_IDLE && req_i) begin
            lat_we      <= we_i;
            lat_addr_o  <= addr_i;
            lat_wdata_o <= wdata_i;
         end
      end
   end

   assign tgt_bank_o = (st == PH_IDLE) ? addr_i[ADDR_W-1 -: BANK_W]
                                       : lat_addr_o[ADDR_W-1 -: BANK_W];
   assign act_o   = !(st == PH_IDLE || st == PH_WAIT);
   assign pre_o   = st == PH_PRE;
   assign wl_o    = st == PH_WL || st == PH_WWL;
   assign se_o    = st == PH_SNS;
   assign bdrv_o  = st == PH_WDRV || st == PH_WWL;
   assign wr_o    = st == PH_WWL;
   assign ready_o = st == PH_SNS || st == PH_WWL;

   p_sense_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      se_o |-> (!pre_o && !wl_o))
      else $error("sense overlaps precharge or word line");

   p_wl_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wl_o |=> !wl_o)
      else $error("word line held beyond one cycle");

   p_pre_then_wl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pre_o |=> (wl_o && !bdrv_o))
      else $error("precharge not followed by read word line");

   p_wl_then_sense_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wl_o && !bdrv_o) |=> se_o)
      else $error("read word line not followed by sense");

   p_drive_then_wl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bdrv_o && !wl_o) |=> (bdrv_o && wl_o))
      else $error("bit drive not followed by write word line");

endmodule

// File: rtl/pm_banked_mem.sv
`timescale 1ns/1ps
module pm_banked_mem #(
   parameter int NBANK    = 4,
   parameter int ROW_W    = 3,
   parameter int COL_W    = 2,
   parameter int DATA_W   = 8,
   parameter int WAKE_CYC = 3
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  req_i,
   input  logic                                  we_i,
   input  logic [$clog2(NBANK)+ROW_W+COL_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]                     wdata_i,
   input  logic [2*NBANK-1:0]                    mode_i,
   output logic                                  ready_o,
   output logic [DATA_W-1:0]                     rdata_o,
   output logic                                  rerr_o,
   output logic [NBANK-1:0]                      bank_en_o,
   output logic                                  pre_o,
   output logic                                  wl_o,
   output logic                                  se_o,
   output logic                                  bdrv_o
);
   import pmb_pkg::*;

   localparam int BANK_W = $clog2(NBANK);
   localparam int ADDR_W = BANK_W + ROW_W + COL_W;

   generate
      if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
         $error("NBANK must be a power of two of at least 2");
      end
      if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ROW_W, COL_W and DATA_W must be positive");
      end
      if (WAKE_CYC < 0) begin : g_bad_wake
         $error("WAKE_CYC must not be negative");
      end
   endgenerate

   logic [BANK_W-1:0] tgt_bank, sel_bank;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata;
   logic [ROW_W-1:0]  row;
   logic [COL_W-1:0]  col;
   logic              act, wr, ok_sel;
   logic [NBANK-1:0]  bank_ok;
   logic [NBANK-1:0]  bank_vld;
   logic [DATA_W-1:0] bank_rd [NBANK];

   pmb_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BANK_W (BANK_W)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i),
      .we_i        (we_i),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .ok_i        (ok_sel),
      .tgt_bank_o  (tgt_bank),
      .lat_addr_o  (lat_addr),
      .lat_wdata_o (lat_wdata),
      .act_o       (act),
      .wr_o        (wr),
      .pre_o       (pre_o),
      .wl_o        (wl_o),
      .se_o        (se_o),
      .bdrv_o      (bdrv_o),
      .ready_o     (ready_o)
   );

   assign ok_sel   = bank_ok[tgt_bank];
   assign sel_bank = lat_addr[ADDR_W-1 -: BANK_W];
   assign row      = lat_addr[COL_W +: ROW_W];
   assign col      = lat_addr[COL_W-1:0];

   generate
      for (genvar g = 0; g < NBANK; g++) begin : g_blk
         assign bank_en_o[g] = act && (sel_bank == BANK_W'(g));

         pmb_wake #(
            .WAKE_CYC (WAKE_CYC)
         ) i_wake (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_i (mode_i[2*g +: 2]),
            .ok_o   (bank_ok[g])
         );

         pmb_bank #(
            .ROW_W  (ROW_W),
            .COL_W  (COL_W),
            .DATA_W (DATA_W)
         ) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (bank_en_o[g]),
            .pd_i    (mode_off(mode_i[2*g +: 2])),
            .wr_i    (wr),
            .row_i   (row),
            .col_i   (col),
            .wdata_i (lat_wdata),
            .rdata_o (bank_rd[g]),
            .rvld_o  (bank_vld[g])
         );
      end
   endgenerate

   assign rdata_o = (se_o && bank_vld[sel_bank]) ? bank_rd[sel_bank] : '0;
   assign rerr_o  = se_o && !bank_vld[sel_bank];

   p_single_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_en_o))
      else $error("more than one block enabled");

   p_idle_no_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(pre_o || wl_o || se_o || bdrv_o) |-> (bank_en_o == '0))
      else $error("block enabled outside an access phase");

   p_ready_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> !ready_o)
      else $error("ready held for two cycles");

   p_ready_has_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (bank_en_o != '0))
      else $error("ready without an enabled block");

   p_error_in_sense_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rerr_o |-> se_o)
      else $error("error flag outside sense");

endmodule

// File: tb/test_pm_banked_mem.sv
`timescale 1ns/1ps
module test_pm_banked_mem;
   localparam int NB  = 4;
   localparam int RW  = 3;
   localparam int CLW = 2;
   localparam int DW  = 8;
   localparam int WK  = 3;
   localparam int AW  = 2 + RW + CLW;
   localparam int WPB = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_i = 1'b0;
   logic we_i = 1'b0;
   logic [AW-1:0]   addr_i = '0;
   logic [DW-1:0]   wdata_i = '0;
   logic [2*NB-1:0] mode_i = '0;
   logic            ready_o, rerr_o, pre_o, wl_o, se_o, bdrv_o;
   logic [DW-1:0]   rdata_o;
   logic [NB-1:0]   bank_en_o;

   pm_banked_mem #(
      .NBANK (NB), .ROW_W (RW), .COL_W (CLW), .DATA_W (DW), .WAKE_CYC (WK)
   ) i_pm_banked_mem (
      .clk (clk), .rst_n (rst_n), .req_i (req_i), .we_i (we_i),
      .addr_i (addr_i), .wdata_i (wdata_i), .mode_i (mode_i),
      .ready_o (ready_o), .rdata_o (rdata_o), .rerr_o (rerr_o),
      .bank_en_o (bank_en_o), .pre_o (pre_o), .wl_o (wl_o),
      .se_o (se_o), .bdrv_o (bdrv_o)
   );

   always #2.5 clk = ~clk;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference model: phase queue, wake counters, word store
   int   q[$];
   bit   pend;
   int   pb, pw, cb, cw;
   bit   pwe;
   logic [DW-1:0] pwd, cwd;
   int   wk[NB];
   logic [DW-1:0] mem[NB][WPB];
   bit   val[NB][WPB];
   bit   okv[NB];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         pend = 1'b0;
         cb = 0; cw = 0;
         for (int b = 0; b < NB; b++) begin
            wk[b] = 0;
            for (int w = 0; w < WPB; w++) val[b][w] = 1'b0;
         end
      end else begin
         for (int b = 0; b < NB; b++) okv[b] = (mode_i[2*b +: 2] == 2'b00) && (wk[b] == 0);
         if (q.size() != 0) begin
            if (q[0] == 5) begin
               mem[cb][cw] = cwd;
               val[cb][cw] = 1'b1;
            end
            void'(q.pop_front());
         end else begin
            if (!pend && req_i) begin
               pend = 1'b1;
               pb = int'(addr_i[AW-1 -: 2]);
               pw = int'(addr_i[4:0]);
               pwe = we_i;
               pwd = wdata_i;
            end
            if (pend && okv[pb]) begin
               pend = 1'b0;
               cb = pb; cw = pw; cwd = pwd;
               if (pwe) begin q.push_back(4); q.push_back(5); end
               else begin q.push_back(1); q.push_back(2); q.push_back(3); end
            end
         end
         for (int b = 0; b < NB; b++) begin
            if (mode_i[2*b +: 2] != 2'b00) wk[b] = WK;
            else if (wk[b] > 0) wk[b] = wk[b] - 1;
            if (mode_i[2*b+1])
               for (int w = 0; w < WPB; w++) val[b][w] = 1'b0;
         end
      end
   end

   int            ph;
   logic [DW-1:0] erd;
   logic          eer;
   logic [NB-1:0] een;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         ph  = (q.size() != 0) ? q[0] : 0;
         een = (ph != 0) ? NB'(1 << cb) : '0;
         eer = (ph == 3) && !val[cb][cw];
         erd = ((ph == 3) && val[cb][cw]) ? mem[cb][cw] : '0;
         chk("R10 ready_o per cycle", 32'(ready_o), 32'((ph == 3) || (ph == 5)));
         chk("R3 pre_o per cycle", 32'(pre_o), 32'(ph == 1));
         chk("R4 wl_o per cycle", 32'(wl_o), 32'((ph == 2) || (ph == 5)));
         chk("R4 se_o per cycle", 32'(se_o), 32'(ph == 3));
         chk("R5 bdrv_o per cycle", 32'(bdrv_o), 32'((ph == 4) || (ph == 5)));
         chk("R2 bank_en_o per cycle", 32'(bank_en_o), 32'(een));
         chk("R1 rdata_o per cycle", 32'(rdata_o), 32'(erd));
         chk("R8 rerr_o per cycle", 32'(rerr_o), 32'(eer));
      end
   end

   logic [DW-1:0] t_rd;
   logic          t_er;
   int            t_lat;

   task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
      t_lat = 0;
      do begin
         @(negedge clk);
         t_lat++;
      end while (!ready_o && t_lat < 500);
      t_rd = rdata_o;
      t_er = rerr_o;
      @(negedge clk);
      req_i = 1'b0; we_i = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: nothing written since reset
      access(1'b0, 7'h00, 8'h00);
      chk("R8 read after reset error", 32'(t_er), 32'd1);
      chk("R8 read after reset data", 32'(t_rd), 32'd0);
      chk("R3 read latency", 32'(t_lat), 32'd3);

      // R1 / R5: fields kept apart
      access(1'b1, 7'h00, 8'h11);
      chk("R5 write latency", 32'(t_lat), 32'd2);
      access(1'b1, 7'h03, 8'h22);
      access(1'b1, 7'h14, 8'h33);
      access(1'b1, 7'h40, 8'h44);
      access(1'b1, 7'h7F, 8'h55);
      access(1'b0, 7'h00, 8'h00);
      chk("R1 col 0 word", 32'(t_rd), 32'h11);
      access(1'b0, 7'h03, 8'h00);
      chk("R1 col 3 word", 32'(t_rd), 32'h22);
      access(1'b0, 7'h14, 8'h00);
      chk("R1 row 5 word", 32'(t_rd), 32'h33);
      access(1'b0, 7'h40, 8'h00);
      chk("R1 block 2 word", 32'(t_rd), 32'h44);
      chk("R1 block 2 no error", 32'(t_er), 32'd0);

      for (int c = 0; c < 4; c++) access(1'b1, AW'(7'h1C + c), DW'(8'hA0 + c));
      for (int c = 0; c < 4; c++) begin
         access(1'b0, AW'(7'h1C + c), 8'h00);
         chk("R1 line column select", 32'(t_rd), 32'(8'hA0 + c));
      end

      // R9 / R7 / R2: sleep block 1 holding data
      access(1'b1, 7'h25, 8'h66);
      @(negedge clk);
      mode_i = 8'b00_00_01_00;
      access(1'b0, 7'h03, 8'h00);
      chk("R2 other block unaffected latency", 32'(t_lat), 32'd3);
      chk("R2 other block unaffected data", 32'(t_rd), 32'h22);

      @(negedge clk);
      req_i = 1'b1; we_i = 1'b0; addr_i = 7'h25;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk("R9 ready low while asleep", 32'(ready_o), 32'd0);
         chk("R9 no enable while asleep", 32'(bank_en_o), 32'd0);
      end
      mode_i = 8'b00_00_00_00;
      t_lat = 0;
      do begin
         @(negedge clk);
         t_lat++;
      end while (!ready_o && t_lat < 500);
      chk("R9 wake-up delay", 32'(t_lat), 32'(WK + 3));
      chk("R7 data kept in sleep", 32'(rdata_o), 32'h66);
      chk("R7 no error after sleep", 32'(rerr_o), 32'd0);
      @(negedge clk);
      req_i = 1'b0;

      // R6 / R8: power-down with both encodings
      mode_i = 8'b11_10_00_00;
      repeat (4) @(negedge clk);
      mode_i = 8'b00_00_00_00;
      repeat (WK + 1) @(negedge clk);
      access(1'b0, 7'h40, 8'h00);
      chk("R8 word lost after power-down", 32'(t_er), 32'd1);
      chk("R8 lost word reads zero", 32'(t_rd), 32'd0);
      access(1'b0, 7'h7F, 8'h00);
      chk("R6 mode 11 is power-down", 32'(t_er), 32'd1);
      access(1'b1, 7'h41, 8'h77);
      access(1'b0, 7'h41, 8'h00);
      chk("R8 rewritten word valid", 32'(t_er), 32'd0);
      chk("R8 rewritten word data", 32'(t_rd), 32'h77);
      access(1'b0, 7'h40, 8'h00);
      chk("R8 other word still invalid", 32'(t_er), 32'd1);
      access(1'b0, 7'h00, 8'h00);
      chk("R6 active block kept data", 32'(t_rd), 32'h11);

      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule